// File: doc/BRIEF.md
# Quasi-Resonant Valley Switch-On Controller

This block decides when the power switch of a valley-switching flyback converter turns on and when it turns off. It receives clean synchronous comparator flags: where the feedback voltage sits against two pairs of counting thresholds (one pair per line level), a feedback over-range flag, the raw zero-crossing detector output, a flag giving whether the zero-crossing level is above the ringing-suppression threshold, and a current-sense trip. It produces the gate drive.

Two small counters drive the turn-on decision. A target counter holds how many valleys to skip. It follows the load slowly: once per evaluation period it steps up, holds or steps down, with hysteresis, and it drops back to one at once on a feedback over-range or on an external request. A valley counter counts the falling zero crossings seen since turn-off. A four-state machine turns the gate on when enough valleys have been counted. A ringing-suppression window, a maximum off time, a leading-edge blanking time and a maximum on time bound it. Every duration is a parameter counted in system clock cycles.

States of the gate machine: `ST_OFF_RING` (gate low, suppression window running), `ST_OFF_WAIT` (gate low, waiting for enough valleys), `ST_ON_BLANK` (gate high, current trip masked) and `ST_ON_RUN` (gate high, current trip live). Transitions: OFF_RING→ON_BLANK on maximum off time, or when the window ends with enough valleys; OFF_RING→OFF_WAIT when the window ends without enough valleys; OFF_WAIT→ON_BLANK on enough valleys or maximum off time; ON_BLANK→OFF_RING on maximum on time, or on a trip in its last blanking cycle; ON_BLANK→ON_RUN when blanking ends with no trip; ON_RUN→OFF_RING on a trip or on maximum on time. The reset state is OFF_RING.

Top module: `qr_valley_ctrl`

## Requirements
- R1: The target count stays within 1 to 7. A step up at 7 or a step down at 1 is ignored.
- R2: At each evaluation tick (every TICK_CYC cycles) the target steps down by one if the selected high flag was seen in the period ending with that tick. Otherwise it holds if the selected low flag was seen. Otherwise it steps up by one.
- R3: When `line_hi_i` is 1 the high-line flag pair (`fb_lo_hl_i`, `fb_hi_hl_i`) is used. When it is 0 the low-line pair (`fb_lo_ll_i`, `fb_hi_ll_i`) is used. The unselected pair has no effect.
- R4: `fb_rst_i` or `force_one_i` high in a cycle sets the target to 1 on the next clock edge, taking priority over a tick.
- R5: `zc_raw_i` passes two synchronizer stages. A 1→0 transition increments the valley count on the third clock edge after it. The count saturates at 7, counts only while the gate is low, and is 0 from the second cycle of every gate-high period.
- R6: The gate stays low at least RS_SHORT_CYC cycles. While `zc_hi_i` is 0 the suppression window lasts RS_LONG_CYC cycles.
- R7: Once the window has ended, the gate rises in the cycle after the valley count is at least the target count.
- R8: The gate never stays low for more than OFF_MAX_CYC consecutive cycles. At that limit it rises whatever the counters hold.
- R9: Each gate-high period lasts at least LEB_CYC cycles. `cs_trip_i` is ignored in its first LEB_CYC-1 cycles.
- R10: The gate never stays high for more than ON_MAX_CYC consecutive cycles.
- R11: `cs_trip_i` high in a gate-high cycle at or after cycle LEB_CYC-1 of that period drives the gate low in the next cycle.
- R12: During reset the gate is low, the valley count is 0 and the target is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| zc_raw_i | input | 1 | Raw zero-crossing comparator output, falling edge = valley |
| zc_hi_i | input | 1 | Zero-crossing level above ringing-suppression threshold |
| cs_trip_i | input | 1 | Current-sense trip flag |
| line_hi_i | input | 1 | Line level: 1 selects the high-line threshold pair |
| fb_lo_ll_i | input | 1 | Feedback above low counting threshold, low-line set |
| fb_hi_ll_i | input | 1 | Feedback above high counting threshold, low-line set |
| fb_lo_hl_i | input | 1 | Feedback above low counting threshold, high-line set |
| fb_hi_hl_i | input | 1 | Feedback above high counting threshold, high-line set |
| fb_rst_i | input | 1 | Feedback above the over-range threshold |
| force_one_i | input | 1 | External request to set the target to one |
| gate_o | output | 1 | Gate drive |
| target_o | output | 3 | Valleys to count before turn-on |
| valley_o | output | 3 | Valleys counted since turn-off |

## Verification
The assertions assume that every flag is synchronous to `clk_i`. They assume the parameters are ordered: RS_SHORT_CYC ≤ RS_LONG_CYC < OFF_MAX_CYC and LEB_CYC < ON_MAX_CYC. They also assume that a selected high flag appears only with its low flag, since the thresholds are ordered. The stimulus drives every input at the falling clock edge, sets the high flag only together with the low flag of the same pair, and uses short durations that respect that ordering. Zero-crossing pulses are at least one cycle wide, so the synchronizer never has to resolve a glitch.

// File: rtl/qr_pkg.sv
package qr_pkg;

    // Largest number of valleys that may be skipped before turn-on
    localparam int SKIP_MAX = 7;
    localparam int SKIP_W   = $clog2(SKIP_MAX + 1);

    typedef logic [SKIP_W-1:0] skip_t;

    // Gate sequencing states
    typedef enum logic [1:0] {
        ST_OFF_RING = 2'd0,
        ST_OFF_WAIT = 2'd1,
        ST_ON_BLANK = 2'd2,
        ST_ON_RUN   = 2'd3
    } gate_state_t;

endpackage

// File: rtl/qr_target_ctr.sv
module qr_target_ctr
    import qr_pkg::*;
#(
    parameter int TICK_CYC = 4_800_000
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  fb_lo_i,
    input  logic  fb_hi_i,
    input  logic  fb_rst_i,
    input  logic  force_one_i,
    output skip_t target_o
);

    localparam int TKW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
    localparam logic [TKW-1:0] TICK_LAST = TKW'(TICK_CYC - 1);
    localparam skip_t ONE = skip_t'(1);
    localparam skip_t TOP = skip_t'(SKIP_MAX);

    logic [TKW-1:0] tick_cnt_q;
    logic           tick;
    logic           seen_lo_q;
    logic           seen_hi_q;
    logic           eff_lo;
    logic           eff_hi;
    skip_t          target_q;

    assign tick   = (tick_cnt_q == TICK_LAST);
    assign eff_lo = seen_lo_q | fb_lo_i;
    assign eff_hi = seen_hi_q | fb_hi_i;

    // Free-running evaluation period
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tick_cnt_q <= '0;
        end else if (tick) begin
            tick_cnt_q <= '0;
        end else begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
        end
    end

    // Flags seen during the running period
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_lo_q <= 1'b0;
            seen_hi_q <= 1'b0;
        end else if (tick) begin
            seen_lo_q <= 1'b0;
            seen_hi_q <= 1'b0;
        end else begin
            seen_lo_q <= eff_lo;
            seen_hi_q <= eff_hi;
        end
    end

    // Saturating target with hysteresis and fast return to one
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            target_q <= ONE;
        end else if (fb_rst_i || force_one_i) begin
            target_q <= ONE;
        end else if (tick) begin
            if (eff_hi) begin
                if (target_q > ONE) target_q <= target_q - 1'b1;
            end else if (!eff_lo) begin
                if (target_q < TOP) target_q <= target_q + 1'b1;
            end
        end
    end

    assign target_o = target_q;

    p_target_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (target_q >= ONE) && (target_q <= TOP));

    p_force_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fb_rst_i || force_one_i) |=> (target_q == ONE));

    p_tick_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fb_rst_i && !force_one_i && !tick) |=> $stable(target_q));

endmodule

// File: rtl/qr_valley_ctr.sv
module qr_valley_ctr
    import qr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  zc_raw_i,
    input  logic  gate_i,
    output skip_t valley_o
);

    localparam skip_t TOP = skip_t'(SKIP_MAX);

    // Synchronizer stages plus one stage for edge detection
    logic [SYNC_STAGES:0] zc_sh_q;
    logic                 zc_fall;
    skip_t                valley_q;

    genvar g;
    generate
        for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) zc_sh_q[g] <= 1'b1;
                    else         zc_sh_q[g] <= zc_raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) zc_sh_q[g] <= 1'b1;
                    else         zc_sh_q[g] <= zc_sh_q[g-1];
                end
            end
        end
    endgenerate

    assign zc_fall = zc_sh_q[SYNC_STAGES] & ~zc_sh_q[SYNC_STAGES-1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            valley_q <= '0;
        end else if (gate_i) begin
            valley_q <= '0;
        end else if (zc_fall && (valley_q != TOP)) begin
            valley_q <= valley_q + 1'b1;
        end
    end

    assign valley_o = valley_q;

    p_clear_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_i |=> (valley_q == '0));

    p_single_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !gate_i |=> ((valley_q == $past(valley_q)) || (valley_q == $past(valley_q) + 3'd1)));

endmodule

// File: rtl/qr_gate_fsm.sv
module qr_gate_fsm
    import qr_pkg::*;
#(
    parameter int RS_SHORT_CYC = 250,
    parameter int RS_LONG_CYC  = 2500,
    parameter int OFF_MAX_CYC  = 4200,
    parameter int LEB_CYC      = 33,
    parameter int ON_MAX_CYC   = 3000
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  skip_t valley_i,
    input  skip_t target_i,
    input  logic  zc_hi_i,
    input  logic  cs_trip_i,
    output logic  gate_o
);

    localparam int TMAX = (OFF_MAX_CYC > ON_MAX_CYC) ? OFF_MAX_CYC : ON_MAX_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    localparam logic [TW-1:0] OFF_LAST  = TW'(OFF_MAX_CYC - 1);
    localparam logic [TW-1:0] ON_LAST   = TW'(ON_MAX_CYC - 1);
    localparam logic [TW-1:0] LEB_LAST  = TW'(LEB_CYC - 1);
    localparam logic [TW-1:0] RSS_LAST  = TW'(RS_SHORT_CYC - 1);
    localparam logic [TW-1:0] RSL_LAST  = TW'(RS_LONG_CYC - 1);
    localparam logic [TW-1:0] OFF_LIM   = TW'(OFF_MAX_CYC);
    localparam logic [TW-1:0] ON_LIM    = TW'(ON_MAX_CYC);
    localparam logic [TW-1:0] LEB_LIM   = TW'(LEB_CYC);
    localparam logic [TW-1:0] RSS_LIM   = TW'(RS_SHORT_CYC);
    localparam logic [TW-1:0] T_SAT     = TW'(TMAX);

    gate_state_t   state_q;
    gate_state_t   state_d;
    logic [TW-1:0] t_q;
    logic [TW-1:0] ring_last;
    logic          valley_ok;
    logic          on_q;
    logic          on_d;

    assign ring_last = zc_hi_i ? RSS_LAST : RSL_LAST;
    assign valley_ok = (valley_i >= target_i);
    assign on_q      = (state_q == ST_ON_BLANK) || (state_q == ST_ON_RUN);
    assign on_d      = (state_d == ST_ON_BLANK) || (state_d == ST_ON_RUN);

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF_RING;
        else         state_q <= state_d;
    end

    // Phase timer: counts cycles since the gate last changed level
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           t_q <= '0;
        else if (on_d != on_q) t_q <= '0;
        else                   t_q <= t_q + 1'b1;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF_RING: begin
                if (t_q >= OFF_LAST) begin
                    state_d = ST_ON_BLANK;
                end else if (t_q >= ring_last) begin
                    state_d = valley_ok ? ST_ON_BLANK : ST_OFF_WAIT;
                end
            end
            ST_OFF_WAIT: begin
                if (valley_ok || (t_q >= OFF_LAST)) state_d = ST_ON_BLANK;
            end
            ST_ON_BLANK: begin
                if (t_q >= ON_LAST) begin
                    state_d = ST_OFF_RING;
                end else if (t_q >= LEB_LAST) begin
                    state_d = cs_trip_i ? ST_OFF_RING : ST_ON_RUN;
                end
            end
            ST_ON_RUN: begin
                if (cs_trip_i || (t_q >= ON_LAST)) state_d = ST_OFF_RING;
            end
            default: state_d = ST_OFF_RING;
        endcase
    end

    // Outputs
    always_comb begin
        gate_o = on_q;
    end

    // Level run lengths observed on the gate output, for the properties below
    logic [TW-1:0] lo_run_q;
    logic [TW-1:0] hi_run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_run_q <= '0;
            hi_run_q <= '0;
        end else begin
            lo_run_q <= gate_o ? '0 : ((lo_run_q == T_SAT) ? lo_run_q : lo_run_q + 1'b1);
            hi_run_q <= !gate_o ? '0 : ((hi_run_q == T_SAT) ? hi_run_q : hi_run_q + 1'b1);
        end
    end

    p_min_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_o) |-> (lo_run_q >= RSS_LIM));

    p_turn_on_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(gate_o) |-> (($past(valley_i) >= $past(target_i)) || (lo_run_q == OFF_LIM)));

    p_max_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lo_run_q <= OFF_LIM);

    p_min_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(gate_o) |-> (hi_run_q >= LEB_LIM));

    p_max_on_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hi_run_q <= ON_LIM);

    p_trip_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_o && (hi_run_q >= LEB_LAST) && cs_trip_i) |=> !gate_o);

endmodule

// File: rtl/qr_valley_ctrl.sv
module qr_valley_ctrl
    import qr_pkg::*;
#(
    parameter int TICK_CYC     = 4_800_000,
    parameter int RS_SHORT_CYC = 250,
    parameter int RS_LONG_CYC  = 2500,
    parameter int OFF_MAX_CYC  = 4200,
    parameter int LEB_CYC      = 33,
    parameter int ON_MAX_CYC   = 3000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              zc_raw_i,
    input  logic              zc_hi_i,
    input  logic              cs_trip_i,
    input  logic              line_hi_i,
    input  logic              fb_lo_ll_i,
    input  logic              fb_hi_ll_i,
    input  logic              fb_lo_hl_i,
    input  logic              fb_hi_hl_i,
    input  logic              fb_rst_i,
    input  logic              force_one_i,
    output logic              gate_o,
    output logic [SKIP_W-1:0] target_o,
    output logic [SKIP_W-1:0] valley_o
);

    logic  fb_lo_sel;
    logic  fb_hi_sel;
    logic  gate;
    skip_t target;
    skip_t valley;

    // Counting thresholds follow the line level
    assign fb_lo_sel = line_hi_i ? fb_lo_hl_i : fb_lo_ll_i;
    assign fb_hi_sel = line_hi_i ? fb_hi_hl_i : fb_hi_ll_i;

    qr_target_ctr #(
        .TICK_CYC (TICK_CYC)
    ) u_target (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fb_lo_i     (fb_lo_sel),
        .fb_hi_i     (fb_hi_sel),
        .fb_rst_i    (fb_rst_i),
        .force_one_i (force_one_i),
        .target_o    (target)
    );

    qr_valley_ctr #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_valley (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .zc_raw_i (zc_raw_i),
        .gate_i   (gate),
        .valley_o (valley)
    );

    qr_gate_fsm #(
        .RS_SHORT_CYC (RS_SHORT_CYC),
        .RS_LONG_CYC  (RS_LONG_CYC),
        .OFF_MAX_CYC  (OFF_MAX_CYC),
        .LEB_CYC      (LEB_CYC),
        .ON_MAX_CYC   (ON_MAX_CYC)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .valley_i  (valley),
        .target_i  (target),
        .zc_hi_i   (zc_hi_i),
        .cs_trip_i (cs_trip_i),
        .gate_o    (gate)
    );

    assign gate_o   = gate;
    assign target_o = target;
    assign valley_o = valley;

endmodule

// File: tb/qr_valley_ctrl_tb.sv
module qr_valley_ctrl_tb;

    localparam int TICK = 64;
    localparam int RSS  = 6;
    localparam int RSL  = 20;
    localparam int OFFM = 40;
    localparam int LEB  = 4;
    localparam int ONM  = 30;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       zc_raw, zc_hi, cs_trip, line_hi;
    logic       lo_ll, hi_ll, lo_hl, hi_hl, fb_rst, force_one;
    logic       gate;
    logic [2:0] target, valley;

    qr_valley_ctrl #(
        .TICK_CYC     (TICK),
        .RS_SHORT_CYC (RSS),
        .RS_LONG_CYC  (RSL),
        .OFF_MAX_CYC  (OFFM),
        .LEB_CYC      (LEB),
        .ON_MAX_CYC   (ONM),
        .SYNC_STAGES  (2)
    ) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .zc_raw_i    (zc_raw),
        .zc_hi_i     (zc_hi),
        .cs_trip_i   (cs_trip),
        .line_hi_i   (line_hi),
        .fb_lo_ll_i  (lo_ll),
        .fb_hi_ll_i  (hi_ll),
        .fb_lo_hl_i  (lo_hl),
        .fb_hi_hl_i  (hi_hl),
        .fb_rst_i    (fb_rst),
        .force_one_i (force_one),
        .gate_o      (gate),
        .target_o    (target),
        .valley_o    (valley)
    );

    int  tests = 0;
    int  fails = 0;
    bit  finished = 0;

    // Behavioural reference state
    bit  m_z1, m_z2, m_z3;
    bit  m_seen_lo, m_seen_hi;
    int  m_valley, m_target, m_tcnt, m_phase, m_t;

    // Observed gate run lengths
    bit  prev_g;
    int  run_len, last_lo, last_hi;

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_z1 = 1; m_z2 = 1; m_z3 = 1;
        m_seen_lo = 0; m_seen_hi = 0;
        m_valley = 0; m_target = 1; m_tcnt = 0;
        m_phase = 0; m_t = 0;
    endtask

    // phase: 0 window, 1 waiting, 2 blanking, 3 on
    task automatic model_step();
        bit fall, sel_lo, sel_hi, e_lo, e_hi, tick, m_on, ok;
        int n_phase, n_t, n_valley, n_target, win;
        fall   = m_z3 && !m_z2;
        sel_lo = line_hi ? lo_hl : lo_ll;
        sel_hi = line_hi ? hi_hl : hi_ll;
        e_lo   = m_seen_lo || sel_lo;
        e_hi   = m_seen_hi || sel_hi;
        tick   = (m_tcnt == TICK - 1);
        m_on   = (m_phase >= 2);
        ok     = (m_valley >= m_target);
        win    = zc_hi ? RSS : RSL;

        n_valley = m_valley;
        if (m_on) n_valley = 0;
        else if (fall && m_valley < 7) n_valley = m_valley + 1;

        n_target = m_target;
        if (fb_rst || force_one) n_target = 1;
        else if (tick) begin
            if (e_hi) begin if (m_target > 1) n_target = m_target - 1; end
            else if (!e_lo) begin if (m_target < 7) n_target = m_target + 1; end
        end

        n_phase = m_phase;
        case (m_phase)
            0: if (m_t >= OFFM - 1) n_phase = 2;
               else if (m_t >= win - 1) n_phase = ok ? 2 : 1;
            1: if (ok || m_t >= OFFM - 1) n_phase = 2;
            2: if (m_t >= ONM - 1) n_phase = 0;
               else if (m_t >= LEB - 1) n_phase = cs_trip ? 0 : 3;
            default: if (cs_trip || m_t >= ONM - 1) n_phase = 0;
        endcase
        n_t = ((n_phase >= 2) != m_on) ? 0 : m_t + 1;

        m_seen_lo = tick ? 1'b0 : e_lo;
        m_seen_hi = tick ? 1'b0 : e_hi;
        m_tcnt    = tick ? 0 : m_tcnt + 1;
        m_z3 = m_z2; m_z2 = m_z1; m_z1 = zc_raw;
        m_valley = n_valley; m_target = n_target;
        m_phase = n_phase; m_t = n_t;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R7 gate vs model", int'(gate), (m_phase >= 2) ? 1 : 0);
        check("R2 target vs model", int'(target), m_target);
        check("R5 valley vs model", int'(valley), m_valley);
        if (gate == prev_g) run_len++;
        else begin
            if (prev_g) last_hi = run_len; else last_lo = run_len;
            run_len = 1;
            prev_g  = gate;
        end
    endtask

    task automatic wait_fall();
        do cycle(); while (!(gate == 1'b0 && run_len == 1));
    endtask

    task automatic wait_rise();
        do cycle(); while (!(gate == 1'b1 && run_len == 1));
    endtask

    // Over two periods: the first settles, the second shows one clean step
    task automatic slope(string req, int dir);
        int v, e;
        repeat (TICK) cycle();
        v = int'(target);
        repeat (TICK) cycle();
        if (dir > 0)      e = (v < 7) ? v + 1 : 7;
        else if (dir < 0) e = (v > 1) ? v - 1 : 1;
        else              e = v;
        check(req, int'(target), e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; zc_raw = 1; zc_hi = 0; cs_trip = 0; line_hi = 0;
        lo_ll = 0; hi_ll = 0; lo_hl = 0; hi_hl = 0; fb_rst = 0; force_one = 0;
        prev_g = 0; run_len = 0; last_lo = 0; last_hi = 0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R12 reset gate", int'(gate), 0);
        check("R12 reset valley", int'(valley), 0);
        check("R12 reset target", int'(target), 1);
        rst_n = 1;

        // Light load: target climbs to the ceiling and stays there
        repeat (6 * TICK + 40) cycle();
        check("R2 climb to ceiling", int'(target), 7);
        repeat (2 * TICK) cycle();
        check("R1 ceiling held", int'(target), 7);

        // No valleys: limits on both levels
        wait_fall();
        wait_rise();
        check("R8 max off length", last_lo, OFFM);
        wait_fall();
        check("R10 max on length", last_hi, ONM);

        // Nine valleys inside a long window, target 7
        zc_hi = 0;
        for (int k = 0; k < 9; k++) begin
            zc_raw = 0; cycle();
            zc_raw = 1; cycle();
        end
        cycle();
        check("R5 valley saturates", int'(valley), 7);
        check("R6 still in long window", int'(gate), 0);
        cycle();
        check("R6 long window length", last_lo, RSL);
        check("R6 on after long window", int'(gate), 1);

        // Trip held from the start of the on period
        cs_trip = 1;
        wait_fall();
        cs_trip = 0;
        check("R9 blanking length", last_hi, LEB);

        // Short window, target forced to one
        lo_ll = 1; force_one = 1; zc_hi = 1;
        cycle();
        force_one = 0;
        check("R4 force to one", int'(target), 1);
        zc_raw = 0; cycle();
        zc_raw = 1;
        wait_rise();
        check("R6 short window length", last_lo, RSS);

        cycle();
        check("R5 cleared while on", int'(valley), 0);
        repeat (8) cycle();
        cs_trip = 1;
        wait_fall();
        cs_trip = 0;
        check("R11 trip turn-off", last_hi, 10);

        // One late valley after the window
        repeat (10) cycle();
        zc_raw = 0; cycle();
        zc_raw = 1;
        wait_rise();
        check("R7 valley turn-on", last_lo, 14);

        // Target dynamics
        lo_ll = 0; hi_ll = 0;
        slope("R2 step up", 1);
        lo_ll = 1; hi_ll = 1;
        slope("R2 step down", -1);
        hi_ll = 0;
        slope("R2 hold", 0);
        line_hi = 1; lo_ll = 1; hi_ll = 1; lo_hl = 0; hi_hl = 0;
        slope("R3 high-line pair up", 1);
        lo_ll = 0; hi_ll = 0; lo_hl = 1; hi_hl = 1;
        slope("R3 high-line pair down", -1);

        line_hi = 0; lo_ll = 0; hi_ll = 0; lo_hl = 0; hi_hl = 0;
        repeat (2 * TICK) cycle();
        fb_rst = 1; cycle();
        fb_rst = 0;
        check("R4 over-range to one", int'(target), 1);
        lo_ll = 1; hi_ll = 1;
        slope("R1 floor held", -1);
        check("R1 floor value", int'(target), 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule